// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus that a target device is holding stuck with SDA low. A controller that finds the bus hung hands the open-drain drive of both lines to this sequencer and pulses `start_i`. The sequencer then runs one fixed recovery pattern. First comes a quiet half-period in which both lines are left released, which acts as a not-acknowledge. Then it clocks SCL through a set number of low-then-high pulses, nine by default, which is enough for any target to finish shifting out a partial byte. Last it forms a stop by pulling SDA low while SCL is released, and then letting SDA go.

Every phase lasts one half-period. The half-period is a count of system clock cycles, read from `half_cnt_i` at the moment the run is accepted. At the end of the run the block reports, through a one-cycle `done_o` pulse and a held status bit, whether SDA was seen high. That tells the controller whether the bus has come free. Normal data transfers and arbitration stay with the controller.

Top module: `i2c_busclr_seq`

## Requirements
- R1: After reset, and whenever no run is in progress, `scl_oe_o`, `sda_oe_o`, `busy_o` and `done_o` are all 0, and `sda_free_o` is 0 until the first run completes. An enable of 1 means the line is pulled low; 0 means it is released.
- R2: A `start_i` high on a clock edge while idle starts a run. `busy_o` is 1 from the cycle after that edge for exactly (2·NUM_PULSES+3)·H cycles, where H is the effective half-period.
- R3: The first half-period of a run has both lines released (the not-acknowledge slot). `sda_oe_o` stays 0 through this slot and through every clock pulse.
- R4: Exactly NUM_PULSES (default 9) SCL pulses follow. Each pulse is H cycles with `scl_oe_o`=1, then H cycles with `scl_oe_o`=0.
- R5: After the last pulse, `sda_oe_o` is 1 with `scl_oe_o` 0 for H cycles. Then both lines are released for one more H-cycle half-period.
- R6: `done_o` is 1 for exactly one cycle, the first cycle in which `busy_o` is back to 0.
- R7: `sda_free_o` takes the level of `sda_in_i` present over the final SYNC_STAGES+1 cycles of the run. It changes in the same cycle as `done_o` and holds until the next run completes.
- R8: A `start_i` received while a run is in progress is ignored. The running sequence keeps its timing, and no second run follows.
- R9: H is `half_cnt_i` as sampled on the accepting edge, with a value of 0 treated as 1. Later changes of `half_cnt_i` during the run have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a recovery run |
| half_cnt_i | input | CNT_W | Half-period length in clock cycles (0 acts as 1) |
| sda_in_i | input | 1 | Level sampled from the SDA pin |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | A recovery run is in progress |
| done_o | output | 1 | One-cycle pulse when a run finishes |
| sda_free_o | output | 1 | SDA was high at the end of the last run |

## Verification
All results count from the clock edge that samples `start_i`. Call the cycle after that edge k=0. `busy_o` and the two line enables are registered, so they follow the phase pattern from k=0: phase number k/H. `done_o` and `sda_free_o` change at k=(2·NUM_PULSES+3)·H. The bench drives inputs and samples outputs on the falling edge. It computes the expected value of each output for every k from the effective half-period, and compares all of them each cycle. During some runs it changes `half_cnt_i` at random and adds extra start pulses, to show that neither moves any of those due cycles.

// File: rtl/busclr_pkg.sv
package busclr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_PREP     = 3'd1,
      ST_LOW      = 3'd2,
      ST_HIGH     = 3'd3,
      ST_STOP_LOW = 3'd4,
      ST_STOP_REL = 3'd5
   } busclr_state_e;

   // phases in one run besides the clock pulses: prep, stop-low, stop-release
   localparam int unsigned EXTRA_PHASES = 3;

   function automatic int unsigned run_phases(input int unsigned pulses);
      return 2 * pulses + EXTRA_PHASES;
   endfunction

endpackage

// File: rtl/busclr_sync.sv
module busclr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES > 4) begin : g_bad_stages
      $error("busclr_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_direct
      assign q_o = d_i;
   end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '1;
         end else begin
            chain_q <= {chain_q[STAGES-1:0], d_i} >> 0;
         end
      end
      assign q_o = chain_q[STAGES-1];
   end

endmodule

// File: rtl/busclr_timer.sv
module busclr_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expire_o
);

   if (CNT_W < 1) begin : g_bad_width
      $error("busclr_timer: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i - CNT_W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign expire_o = (cnt_q == '0);

   AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> (load_val_i != '0)); // R9

   AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !expire_o) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R4

endmodule

// File: rtl/busclr_fsm.sv
module busclr_fsm
   import busclr_pkg::*;
#(
   parameter int unsigned NUM_PULSES = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic expire_i,
   input  logic sda_s_i,
   output logic accept_o,
   output logic load_o,
   output logic scl_oe_o,
   output logic sda_oe_o,
   output logic busy_o,
   output logic done_o,
   output logic sda_free_o
);

   localparam int unsigned PC_W = (NUM_PULSES > 1) ? $clog2(NUM_PULSES) : 1;
   localparam logic [PC_W-1:0] LAST_PULSE = PC_W'(NUM_PULSES - 1);

   if (NUM_PULSES < 1) begin : g_bad_pulses
      $error("busclr_fsm: NUM_PULSES must be at least 1");
   end

   busclr_state_e   state_q, state_d;
   logic [PC_W-1:0] pc_q, pc_d;
   logic            finish;

   always_comb begin
      state_d  = state_q;
      pc_d     = pc_q;
      load_o   = 1'b0;
      accept_o = 1'b0;
      finish   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d  = ST_PREP;
               pc_d     = '0;
               load_o   = 1'b1;
               accept_o = 1'b1;
            end
         end
         ST_PREP: begin
            if (expire_i) begin
               state_d = ST_LOW;
               load_o  = 1'b1;
            end
         end
         ST_LOW: begin
            if (expire_i) begin
               state_d = ST_HIGH;
               load_o  = 1'b1;
            end
         end
         ST_HIGH: begin
            if (expire_i) begin
               load_o = 1'b1;
               if (pc_q == LAST_PULSE) begin
                  state_d = ST_STOP_LOW;
               end else begin
                  state_d = ST_LOW;
                  pc_d    = pc_q + PC_W'(1);
               end
            end
         end
         ST_STOP_LOW: begin
            if (expire_i) begin
               state_d = ST_STOP_REL;
               load_o  = 1'b1;
            end
         end
         ST_STOP_REL: begin
            if (expire_i) begin
               state_d = ST_IDLE;
               finish  = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         pc_q       <= '0;
         scl_oe_o   <= 1'b0;
         sda_oe_o   <= 1'b0;
         busy_o     <= 1'b0;
         done_o     <= 1'b0;
         sda_free_o <= 1'b0;
      end else begin
         state_q  <= state_d;
         pc_q     <= pc_d;
         scl_oe_o <= (state_d == ST_LOW);
         sda_oe_o <= (state_d == ST_STOP_LOW);
         busy_o   <= (state_d != ST_IDLE);
         done_o   <= finish;
         if (finish) begin
            sda_free_o <= sda_s_i;
         end
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R6

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o))); // R6

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !expire_i) |=> busy_o); // R8

   AST_FREE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(sda_free_o)); // R7

endmodule

// File: rtl/i2c_busclr_seq.sv
module i2c_busclr_seq
   import busclr_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned NUM_PULSES  = 9,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] half_cnt_i,
   input  logic             sda_in_i,
   output logic             scl_oe_o,
   output logic             sda_oe_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             sda_free_o
);

   localparam int unsigned PHASES = run_phases(NUM_PULSES);
   localparam int unsigned CHK_W  = $clog2(NUM_PULSES + 2);

   if (PHASES < 5) begin : g_bad_phases
      $error("i2c_busclr_seq: at least one pulse is required");
   end

   logic             accept, load, expire, sda_s;
   logic [CNT_W-1:0] half_q, half_in, load_val;

   // zero half-period is promoted to a single cycle
   assign half_in  = (half_cnt_i == '0) ? CNT_W'(1) : half_cnt_i;
   assign load_val = accept ? half_in : half_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= CNT_W'(1);
      end else if (accept) begin
         half_q <= half_in;
      end
   end

   busclr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (sda_in_i),
      .q_o   (sda_s)
   );

   busclr_timer #(.CNT_W(CNT_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .load_val_i (load_val),
      .expire_o   (expire)
   );

   busclr_fsm #(.NUM_PULSES(NUM_PULSES)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .expire_i   (expire),
      .sda_s_i    (sda_s),
      .accept_o   (accept),
      .load_o     (load),
      .scl_oe_o   (scl_oe_o),
      .sda_oe_o   (sda_oe_o),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .sda_free_o (sda_free_o)
   );

   // pulse tally used only by the checks below
   logic [CHK_W-1:0] rise_cnt_q;
   logic             scl_prev_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_cnt_q <= '0;
         scl_prev_q <= 1'b0;
      end else begin
         scl_prev_q <= scl_oe_o;
         if (accept) begin
            rise_cnt_q <= '0;
         end else if (scl_oe_o && !scl_prev_q) begin
            rise_cnt_q <= rise_cnt_q + CHK_W'(1);
         end
      end
   end

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!scl_oe_o && !sda_oe_o)); // R1

   AST_NACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      scl_oe_o |-> !sda_oe_o); // R3

   AST_PULSE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (rise_cnt_q == CHK_W'(NUM_PULSES))); // R4

   AST_SCL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !expire) |=> $stable(scl_oe_o)); // R4

   AST_HALF_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !accept) |=> $stable(half_q)); // R9

endmodule

// File: tb/sim_i2c_busclr_seq.sv
module sim_i2c_busclr_seq;

   localparam int CLK_PERIOD = 10;
   localparam int CW         = 16;
   localparam int PULSES     = 9;
   localparam int PHASES     = 2 * PULSES + 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [CW-1:0] half_cnt_i = '0;
   logic          sda_in_i = 1'b0;
   logic          scl_oe_o, sda_oe_o, busy_o, done_o, sda_free_o;

   int errors = 0;
   int checks = 0;
   bit ended  = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   i2c_busclr_seq #(.CNT_W(CW), .NUM_PULSES(PULSES), .SYNC_STAGES(2)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .half_cnt_i (half_cnt_i),
      .sda_in_i   (sda_in_i),
      .scl_oe_o   (scl_oe_o),
      .sda_oe_o   (sda_oe_o),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .sda_free_o (sda_free_o)
   );

   task automatic chk(input string req, input logic got, input logic exp, input int k);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s at k=%0d: got %b expected %b", req, k, got, exp);
      end
   endtask

   // expected {busy, scl_oe, sda_oe, done} at cycle k of a run with half-period h
   function automatic logic [3:0] exp_vec(input int k, input int h);
      int ph;
      ph = k / h;
      if (k >= PHASES * h) return {1'b0, 1'b0, 1'b0, (k == PHASES * h)};
      if (ph == 0) return 4'b1000;                          // not-acknowledge slot
      if (ph <= 2 * PULSES) return {1'b1, (ph % 2 == 1), 1'b0, 1'b0};
      if (ph == 2 * PULSES + 1) return 4'b1010;             // stop: SDA low
      return 4'b1000;                                       // final release
   endfunction

   task automatic run_seq(input int h_in, input logic lvl, input bit noise);
      int h;
      logic [3:0] e;
      h = (h_in == 0) ? 1 : h_in;
      @(negedge clk);
      half_cnt_i = CW'(h_in);
      sda_in_i   = lvl;
      start_i    = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 0; k <= PHASES * h + 1; k++) begin
         e = exp_vec(k, h);
         chk("R2 busy", busy_o, e[3], k);
         chk("R4 scl_oe", scl_oe_o, e[2], k);
         chk((k < h) ? "R3 sda_oe" : "R5 sda_oe", sda_oe_o, e[1], k);
         chk("R6 done", done_o, e[0], k);
         if (k >= PHASES * h) chk("R7 sda_free", sda_free_o, lvl, k);
         // R8 / R9: disturb inputs while busy
         if (noise && k < PHASES * h - 1) begin
            half_cnt_i = CW'($urandom_range(0, 7));
            start_i    = ($urandom_range(0, 3) == 0);
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
      end
      start_i = 1'b0;
      // R1: quiet after the run, no second run from ignored starts (R8)
      repeat (3) begin
         chk("R1 idle busy", busy_o, 1'b0, -1);
         chk("R8 no restart scl", scl_oe_o, 1'b0, -1);
         @(negedge clk);
      end
   endtask

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 scl_oe", scl_oe_o, 1'b0, -1);
      chk("R1 sda_oe", sda_oe_o, 1'b0, -1);
      chk("R1 busy", busy_o, 1'b0, -1);
      chk("R1 done", done_o, 1'b0, -1);
      chk("R1 sda_free", sda_free_o, 1'b0, -1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 busy after reset", busy_o, 1'b0, -1);
      // directed corners
      run_seq(1, 1'b1, 1'b0);
      run_seq(0, 1'b0, 1'b0);    // R9 zero acts as one
      run_seq(3, 1'b1, 1'b0);
      run_seq(2, 1'b0, 1'b1);    // R8 R9 disturbance
      run_seq(0, 1'b1, 1'b1);
      // constrained random runs
      for (int i = 0; i < 20; i++) begin
         run_seq($urandom_range(0, 6), logic'($urandom_range(0, 1)),
                 bit'($urandom_range(0, 1)));
      end
      // R7: status holds while idle with SDA moving
      sda_in_i = ~sda_free_o;
      repeat (4) @(negedge clk);
      chk("R7 sda_free held", sda_free_o, ~sda_in_i, -1);
      if (!ended) begin
         ended = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule